// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's store path and a memory-side write port. It holds a small pool of 64-byte line buffers that absorb weakly ordered write-combining stores. Each buffer keeps the line address, the line data and a per-byte valid mask. Stores that land on an open line merge into it. Lines leave as bus write transactions. A complete line goes out as one burst. A partly written line goes out as a series of aligned 8-byte chunk writes.

A buffer is evicted for one of these reasons:
- a store that is not write-combining touches its line;
- a whole-line direct store merges into it;
- a serializing flush request arrives;
- an interrupt arrives;
- a new line needs a slot and every buffer is taken.

A load probe only reports whether a line is held, and never causes an eviction. On the store port, the kind code selects the behaviour: 0 is a write-combining store, 2 is a 64-byte direct store, and 1 or 3 is any other memory type. Addresses are line addresses, so a direct store is 64-byte aligned by construction.

Top module: `wc_combine_buf`

## Requirements
- R1: After reset no buffer is held: `tx_valid` is 0 and `ld_hit` is 0 for any probed line.
- R2: A write-combining store (kind 0) to a held line overwrites only its enabled bytes in the cycle it is accepted. A later store to the same byte wins over an earlier one.
- R3: When all 64 bytes of a buffer are valid, the eviction is one transaction with `tx_mask` = 8'hFF and every bit of `tx_be` set.
- R4: A partly valid buffer leaves as chunk transactions. Each has a one-hot `tx_mask` whose bit c covers bytes 8c..8c+7, and a `tx_be` equal to the valid bytes of that chunk. Chunks are sent in ascending order, and chunks with no valid byte are skipped. On every transaction, `tx_be` stays inside the chunks named by `tx_mask`.
- R5: A kind 1 or kind 3 store to a held line is stalled until that line has been fully evicted, and is then forwarded. Such a store to a line that is not held is forwarded as a single transaction. Its `tx_be` equals `st_be`, and its `tx_mask` marks every chunk that `st_be` touches.
- R6: `ld_hit` reports whether a valid probe hits a held line, and a probe never starts an eviction.
- R7: While `flush_req` is high, stores are held off and all buffers are evicted. `flush_ack` rises only once no buffer is held and no eviction is in flight.
- R8: A pulse on `irq`, even one cycle long, causes every held buffer to be evicted.
- R9: A direct store (kind 2) to a line that is not held is forwarded as one full-line transaction and does not allocate a buffer. `st_be` is ignored for this kind.
- R10: A direct store to a held line overwrites all 64 bytes of that line. The result then leaves at once as a single full-line transaction.
- R11: The pool holds 4 lines. A write-combining store that misses while all buffers are held is stalled. The buffer allocated earliest is evicted first, and then the new line takes the freed slot.
- R12: Once `tx_valid` is high, it stays high until `tx_ready` is sampled high, and the line, chunk mask and byte enables do not change during that time.
- R13: A write-combining store with no byte enabled is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted at this edge |
| st_kind | input | 2 | 0 write-combining, 2 direct 64-byte, 1/3 other memory type |
| st_line | input | LINE_AW (26) | Store line address |
| st_be | input | LINE_BYTES (64) | Per-byte store enables |
| st_data | input | 8*LINE_BYTES (512) | Store line data |
| flush_req | input | 1 | Serializing flush request, held until acknowledged |
| flush_ack | output | 1 | Flush complete |
| irq | input | 1 | Interrupt event; starts a full drain |
| ld_valid | input | 1 | Load probe valid |
| ld_line | input | LINE_AW (26) | Load probe line address |
| ld_hit | output | 1 | Probe hits a held line |
| tx_valid | output | 1 | Write transaction valid |
| tx_ready | input | 1 | Memory side accepts the transaction |
| tx_line | output | LINE_AW (26) | Transaction line address |
| tx_mask | output | LINE_BYTES/CHUNK_BYTES (8) | Chunks carried by the transaction |
| tx_be | output | LINE_BYTES (64) | Valid bytes within the transaction |
| tx_data | output | 8*LINE_BYTES (512) | Line data |

## Verification
The properties assume that the store side keeps `st_valid` high and leaves its whole payload unchanged until `st_ready` is seen. A forwarded store drives the write port straight from those inputs, so R12 holds only under this assumption. The load-probe property also assumes that the probe line stays put across the two cycles it compares. The bench drives each store through one task. That task raises the request a little after a clock edge and holds every field until a falling-edge sample shows acceptance. It then drops the request after the next edge. The probe line is only moved between checks.

// File: rtl/wc_combine_buf.sv
module wc_combine_buf #(
  parameter int NUM_BUF     = 4,
  parameter int LINE_AW     = 26,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 8,
  localparam int DW         = LINE_BYTES * 8,
  localparam int NCHUNK     = LINE_BYTES / CHUNK_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [1:0]            st_kind,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic [DW-1:0]         st_data,
  input  logic                  flush_req,
  output logic                  flush_ack,
  input  logic                  irq,
  input  logic                  ld_valid,
  input  logic [LINE_AW-1:0]    ld_line,
  output logic                  ld_hit,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [LINE_AW-1:0]    tx_line,
  output logic [NCHUNK-1:0]     tx_mask,
  output logic [LINE_BYTES-1:0] tx_be,
  output logic [DW-1:0]         tx_data
);
  localparam int IW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [1:0] KIND_WC = 2'd0;
  localparam logic [1:0] KIND_DIRECT = 2'd2;

  logic [NUM_BUF-1:0]    bv;
  logic [LINE_AW-1:0]    bline [NUM_BUF];
  logic [LINE_BYTES-1:0] bmask [NUM_BUF];
  logic [DW-1:0]         bdata [NUM_BUF];
  logic [IW-1:0]         brank [NUM_BUF];
  logic                  busy, pass_hold, irq_pend;
  logic [IW-1:0]         ev_idx;

  logic [NUM_BUF-1:0] st_hitv, ld_hitv;
  logic               st_hit, any_free;
  logic [IW-1:0]      hit_idx, free_idx, old_idx, low_idx;

  always_comb begin
    st_hit = 1'b0; any_free = 1'b0;
    hit_idx = '0; free_idx = '0; old_idx = '0; low_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      st_hitv[i] = bv[i] && (bline[i] == st_line);
      ld_hitv[i] = bv[i] && (bline[i] == ld_line);
      if (st_hitv[i]) begin st_hit = 1'b1; hit_idx = IW'(i); end
      if (!bv[i]) begin any_free = 1'b1; free_idx = IW'(i); end
      if (bv[i] && brank[i] == '0) old_idx = IW'(i);
      if (bv[i]) low_idx = IW'(i);
    end
  end

  wire any_v = |bv;
  assign ld_hit = ld_valid && (|ld_hitv);

  wire [LINE_BYTES-1:0] em = bmask[ev_idx];
  wire ev_full = &em;
  logic [NCHUNK-1:0]     ev_ch, st_ch;
  logic [LINE_BYTES-1:0] ev_chb;

  always_comb begin
    ev_ch = '0; ev_chb = '0;
    for (int c = NCHUNK - 1; c >= 0; c--) begin
      st_ch[c] = |st_be[c*CHUNK_BYTES +: CHUNK_BYTES];
      if (|em[c*CHUNK_BYTES +: CHUNK_BYTES]) begin
        ev_ch  = NCHUNK'(1) << c;
        ev_chb = LINE_BYTES'({CHUNK_BYTES{1'b1}}) << (c * CHUNK_BYTES);
      end
    end
  end

  wire ev_last = ev_full || ((em & ~ev_chb) == '0);
  wire is_wc   = (st_kind == KIND_WC);
  wire is_dir  = (st_kind == KIND_DIRECT);
  wire drain   = flush_req || irq || irq_pend;
  wire [LINE_BYTES-1:0] wr_be = is_dir ? '1 : st_be;

  logic start_ev, do_merge, do_alloc, pass;
  logic [IW-1:0] start_idx;

  always_comb begin
    st_ready = 1'b0; start_ev = 1'b0; start_idx = low_idx;
    do_merge = 1'b0; do_alloc = 1'b0; pass = 1'b0;
    if (!busy) begin
      if (pass_hold) begin
        pass = 1'b1; st_ready = tx_ready;
      end else if (drain && any_v) begin
        start_ev = 1'b1;
      end else if (st_valid) begin
        if (is_wc) begin
          if (st_be == '0) st_ready = 1'b1;
          else if (st_hit) begin do_merge = 1'b1; st_ready = 1'b1; end
          else if (any_free) begin do_alloc = 1'b1; st_ready = 1'b1; end
          else begin start_ev = 1'b1; start_idx = old_idx; end
        end else if (st_hit) begin
          start_ev = 1'b1; start_idx = hit_idx;
          if (is_dir) begin do_merge = 1'b1; st_ready = 1'b1; end
        end else begin
          pass = 1'b1; st_ready = tx_ready;
        end
      end
    end
  end

  assign flush_ack = flush_req && !busy && !any_v;
  assign tx_valid  = busy || pass;
  assign tx_line   = busy ? bline[ev_idx] : st_line;
  assign tx_mask   = busy ? (ev_full ? '1 : ev_ch) : (is_dir ? '1 : st_ch);
  assign tx_be     = busy ? (ev_full ? '1 : (em & ev_chb)) : wr_be;
  assign tx_data   = busy ? bdata[ev_idx] : st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv <= '0; busy <= 1'b0; pass_hold <= 1'b0; irq_pend <= 1'b0; ev_idx <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        bline[i] <= '0; bmask[i] <= '0; bdata[i] <= '0; brank[i] <= '0;
      end
    end else begin
      pass_hold <= pass && !tx_ready;
      if (irq) irq_pend <= 1'b1;
      else if (!any_v) irq_pend <= 1'b0;
      if (start_ev) begin
        busy   <= 1'b1;
        ev_idx <= start_idx;
      end
      if (do_alloc) begin
        bv[free_idx]    <= 1'b1;
        bline[free_idx] <= st_line;
        bmask[free_idx] <= st_be;
        bdata[free_idx] <= st_data;
        brank[free_idx] <= IW'($countones(bv));
      end
      if (do_merge) begin
        bmask[hit_idx] <= bmask[hit_idx] | wr_be;
        for (int b = 0; b < LINE_BYTES; b++)
          if (wr_be[b]) bdata[hit_idx][b*8 +: 8] <= st_data[b*8 +: 8];
      end
      if (busy && tx_ready) begin
        if (ev_last) begin
          busy          <= 1'b0;
          bv[ev_idx]    <= 1'b0;
          bmask[ev_idx] <= '0;
          for (int k = 0; k < NUM_BUF; k++)
            if (bv[k] && brank[k] > brank[ev_idx]) brank[k] <= brank[k] - 1'b1;
        end else begin
          bmask[ev_idx] <= em & ~ev_chb;
        end
      end
    end
  end
endmodule

// File: rtl/wc_combine_buf_sva.sv
module wc_combine_buf_sva #(
  parameter int LINE_AW     = 26,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 8,
  localparam int NCHUNK     = LINE_BYTES / CHUNK_BYTES
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic                  st_ready,
  input logic                  flush_req,
  input logic                  flush_ack,
  input logic                  irq,
  input logic                  ld_valid,
  input logic [LINE_AW-1:0]    ld_line,
  input logic                  ld_hit,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic [LINE_AW-1:0]    tx_line,
  input logic [NCHUNK-1:0]     tx_mask,
  input logic [LINE_BYTES-1:0] tx_be
);
  logic [LINE_BYTES-1:0] cover_b;
  always_comb
    for (int b = 0; b < LINE_BYTES; b++) cover_b[b] = tx_mask[b / CHUNK_BYTES];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_line) && $stable(tx_mask) && $stable(tx_be)); // R12

  AST_BE_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_be & ~cover_b) == '0); // R4

  AST_PROBE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_hit && !tx_valid && !st_valid ##1 ld_valid && ld_line == $past(ld_line) |-> ld_hit); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ack && ld_valid |-> !ld_hit); // R7

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack && !tx_valid |-> !st_ready); // R7

  AST_IRQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ld_valid && ld_hit && !tx_valid |-> !st_ready); // R8
endmodule

bind wc_combine_buf wc_combine_buf_sva #(
  .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES)
) u_sva (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .flush_req(flush_req), .flush_ack(flush_ack), .irq(irq),
  .ld_valid(ld_valid), .ld_line(ld_line), .ld_hit(ld_hit),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
  .tx_mask(tx_mask), .tx_be(tx_be)
);

// File: tb/wc_combine_buf_tb.sv
module wc_combine_buf_tb;
  localparam int LAW = 26;
  localparam int LB  = 64;
  localparam int NCH = 8;
  localparam int DW  = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [1:0] st_kind = '0;
  logic [LAW-1:0] st_line = '0;
  logic [LB-1:0] st_be = '0;
  logic [DW-1:0] st_data = '0;
  logic flush_req = 1'b0, flush_ack, irq = 1'b0;
  logic ld_valid = 1'b0, ld_hit;
  logic [LAW-1:0] ld_line = '0;
  logic tx_valid, tx_ready = 1'b1;
  logic [LAW-1:0] tx_line;
  logic [NCH-1:0] tx_mask;
  logic [LB-1:0] tx_be;
  logic [DW-1:0] tx_data;

  always #4 clk = ~clk;

  wc_combine_buf u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_kind(st_kind),
    .st_line(st_line), .st_be(st_be), .st_data(st_data), .flush_req(flush_req),
    .flush_ack(flush_ack), .irq(irq), .ld_valid(ld_valid), .ld_line(ld_line), .ld_hit(ld_hit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .tx_mask(tx_mask),
    .tx_be(tx_be), .tx_data(tx_data));

  int checks = 0, fails = 0, rdy_mode = 0, lg_n = 0, base = 0, be_bad = 0;
  logic [DW-1:0]  ref_mem [64];
  logic [DW-1:0]  shd_mem [64];
  logic [LAW-1:0] lg_line [256];
  logic [NCH-1:0] lg_mask [256];
  logic [LB-1:0]  lg_be   [256];
  logic [DW-1:0]  lg_data [256];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [LB-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < LB; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_line();
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic int nt();
    return lg_n - base;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin ref_mem[i] = '0; shd_mem[i] = '0; end
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      logic [LB-1:0] cv;
      for (int b = 0; b < LB; b++) cv[b] = tx_mask[b / 8];
      if ((tx_be & ~cv) != '0) be_bad++;
      shd_mem[tx_line[5:0]] = merge(shd_mem[tx_line[5:0]], tx_data, tx_be);
      if (lg_n < 256) begin
        lg_line[lg_n] = tx_line; lg_mask[lg_n] = tx_mask;
        lg_be[lg_n] = tx_be; lg_data[lg_n] = tx_data;
      end
      lg_n++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: tx_ready = 1'b1;
        1: tx_ready = ($urandom % 3) != 0;
        default: tx_ready = 1'b0;
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  task automatic store(input logic [1:0] k, input int line, input logic [LB-1:0] be,
                       input logic [DW-1:0] d);
    @(posedge clk); #1;
    st_valid = 1'b1; st_kind = k; st_line = LAW'(line); st_be = be; st_data = d;
    do @(negedge clk); while (!st_ready);
    ref_mem[line] = merge(ref_mem[line], d, (k == 2'd2) ? '1 : be);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_flush(output int seen_at_ack);
    @(posedge clk); #1;
    flush_req = 1'b1;
    do @(negedge clk); while (!flush_ack);
    seen_at_ack = nt();
    @(posedge clk); #1;
    flush_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe(input int line);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_line = LAW'(line);
    @(negedge clk);
  endtask

  initial begin
    int sa;
    logic [DW-1:0] d, p;
    void'($urandom(32'h5eed));
    ld_valid = 1'b1;
    idle(3);
    chk(tx_valid == 1'b0, "R1", "tx_valid in reset", DW'(tx_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2);
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", DW'(tx_valid), 0);
    chk(ld_hit == 1'b0, "R1", "ld_hit after reset", DW'(ld_hit), 0);

    // R2 and R4: byte override, then two partial chunks in ascending order
    base = lg_n;
    d = '0; d[7:0] = 8'hAA;
    store(2'd0, 1, 64'h1, d);
    d = '0; d[7:0] = 8'hBB; d[26*8 +: 8] = 8'hCC;
    store(2'd0, 1, 64'h1 | (64'h1 << 26), d);
    do_flush(sa);
    chk(nt() == 2, "R4", "partial chunk count", DW'(nt()), 2);
    chk(lg_mask[base] == 8'h01 && lg_be[base] == 64'h1, "R4", "first chunk mask", DW'(lg_mask[base]), 1);
    chk(lg_data[base][7:0] == 8'hBB, "R2", "later store wins", DW'(lg_data[base][7:0]), DW'(8'hBB));
    chk(lg_mask[base+1] == 8'h08 && lg_be[base+1] == (64'h1 << 26), "R4", "second chunk",
        DW'(lg_be[base+1]), DW'(64'h1 << 26));
    chk(lg_data[base+1][26*8 +: 8] == 8'hCC, "R2", "merged byte", DW'(lg_data[base+1][26*8 +: 8]), DW'(8'hCC));

    // R3: full line leaves as one burst
    base = lg_n;
    store(2'd0, 2, {32'h0, 32'hFFFF_FFFF}, rnd_line());
    store(2'd0, 2, {32'hFFFF_FFFF, 32'h0}, rnd_line());
    do_flush(sa);
    chk(nt() == 1, "R3", "burst count", DW'(nt()), 1);
    chk(lg_mask[base] == 8'hFF && lg_be[base] == '1, "R3", "burst mask", DW'(lg_mask[base]), DW'(8'hFF));
    chk(lg_data[base] == ref_mem[2], "R3", "burst data", lg_data[base], ref_mem[2]);

    // R6: probe hit does not evict
    base = lg_n;
    store(2'd0, 3, 64'hF0, rnd_line());
    probe(3);
    idle(6);
    chk(ld_hit == 1'b1, "R6", "probe hit held line", DW'(ld_hit), 1);
    chk(nt() == 0, "R6", "no eviction on probe", DW'(nt()), 0);
    probe(9);
    chk(ld_hit == 1'b0, "R6", "probe miss", DW'(ld_hit), 0);

    // R5: non-WC store over a held line evicts it first
    base = lg_n;
    d = '0; d[47:40] = 8'h5A;
    store(2'd1, 3, 64'h1 << 5, d);
    idle(3);
    chk(nt() == 2, "R5", "evict then forward count", DW'(nt()), 2);
    chk(lg_line[base] == LAW'(3) && lg_be[base] == 64'hF0, "R5", "buffer out first", DW'(lg_be[base]), DW'(64'hF0));
    chk(lg_be[base+1] == (64'h1 << 5) && lg_data[base+1][47:40] == 8'h5A, "R5", "store forwarded",
        DW'(lg_be[base+1]), DW'(64'h1 << 5));
    probe(3);
    chk(ld_hit == 1'b0, "R5", "line released", DW'(ld_hit), 0);

    // R5: non-WC miss forwarded with touched chunks
    base = lg_n;
    store(2'd3, 7, 64'h0000_00FF_0003_0000, rnd_line());
    idle(2);
    chk(nt() == 1 && lg_mask[base] == 8'h14, "R5", "forward chunk mask", DW'(lg_mask[base]), DW'(8'h14));

    // R9: direct miss, no allocation
    base = lg_n;
    p = rnd_line();
    store(2'd2, 4, '0, p);
    idle(2);
    chk(nt() == 1 && lg_mask[base] == 8'hFF && lg_be[base] == '1, "R9", "direct single tx",
        DW'(lg_mask[base]), DW'(8'hFF));
    chk(lg_data[base] == p, "R9", "direct data", lg_data[base], p);
    probe(4);
    chk(ld_hit == 1'b0, "R9", "no buffer allocated", DW'(ld_hit), 0);

    // R10: direct hit merges and leaves at once
    base = lg_n;
    d = '0; d[7:0] = 8'h11;
    store(2'd0, 5, 64'h1, d);
    p = rnd_line();
    store(2'd2, 5, '0, p);
    idle(3);
    chk(nt() == 1 && lg_mask[base] == 8'hFF, "R10", "one full tx", DW'(nt()), 1);
    chk(lg_data[base] == p, "R10", "direct overwrites line", lg_data[base], p);
    probe(5);
    chk(ld_hit == 1'b0, "R10", "line released", DW'(ld_hit), 0);

    // R11: capacity and oldest-first replacement
    base = lg_n;
    for (int l = 10; l < 15; l++) store(2'd0, l, 64'h1, rnd_line());
    idle(2);
    chk(nt() == 1 && lg_line[base] == LAW'(10), "R11", "oldest evicted", DW'(lg_line[base]), 10);
    probe(14);
    chk(ld_hit == 1'b1, "R11", "new line held", DW'(ld_hit), 1);
    probe(10);
    chk(ld_hit == 1'b0, "R11", "oldest gone", DW'(ld_hit), 0);
    probe(11);
    chk(ld_hit == 1'b1, "R11", "others kept", DW'(ld_hit), 1);
    do_flush(sa);
    chk(nt() == 5, "R11", "all lines out", DW'(nt()), 5);

    // R8: one-cycle interrupt drains all
    base = lg_n;
    store(2'd0, 20, 64'h3, rnd_line());
    store(2'd0, 21, 64'h300, rnd_line());
    @(posedge clk); #1; irq = 1'b1;
    @(posedge clk); #1; irq = 1'b0;
    idle(5);
    chk(nt() == 2, "R8", "interrupt drain count", DW'(nt()), 2);
    probe(20);
    chk(ld_hit == 1'b0, "R8", "line 20 gone", DW'(ld_hit), 0);
    probe(21);
    chk(ld_hit == 1'b0, "R8", "line 21 gone", DW'(ld_hit), 0);

    // R13: empty enable store
    base = lg_n;
    store(2'd0, 30, '0, rnd_line());
    idle(2);
    probe(30);
    chk(ld_hit == 1'b0 && nt() == 0, "R13", "no effect", DW'(ld_hit), 0);

    // R7: flush acknowledged only after eviction
    base = lg_n;
    store(2'd0, 40, 64'hFF00, rnd_line());
    do_flush(sa);
    chk(sa == 1, "R7", "tx done before ack", DW'(sa), 1);
    probe(40);
    chk(ld_hit == 1'b0, "R7", "empty after flush", DW'(ld_hit), 0);

    // R12: held transaction while stalled
    rdy_mode = 2;
    @(posedge clk); #1;
    st_valid = 1'b1; st_kind = 2'd1; st_line = LAW'(8); st_be = 64'h1; st_data = rnd_line();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_line == LAW'(8) && !st_ready, "R12", "stalled tx held", DW'(tx_line), 8);
    end
    rdy_mode = 0;
    do @(negedge clk); while (!st_ready);
    ref_mem[8] = merge(ref_mem[8], st_data, st_be);
    @(posedge clk); #1; st_valid = 1'b0;

    // Random mix against a memory image
    rdy_mode = 1;
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 20;
      int ln = 50 + ($urandom % 4);
      logic [LB-1:0] be = {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 4 == 0) be = {$urandom, $urandom} | {$urandom, $urandom};
      if (r < 12) store(2'd0, ln, be, rnd_line());
      else if (r < 15) store(2'd1, ln, be, rnd_line());
      else if (r < 17) store(2'd2, ln, be, rnd_line());
      else if (r == 17) do_flush(sa);
      else if (r == 18) begin
        @(posedge clk); #1; irq = 1'b1;
        @(posedge clk); #1; irq = 1'b0;
      end else idle(1 + $urandom % 3);
    end
    do_flush(sa);
    rdy_mode = 0;
    idle(2);
    for (int l = 50; l < 54; l++)
      chk(shd_mem[l] == ref_mem[l], "R2", "random line image", shd_mem[l], ref_mem[l]);
    chk(be_bad == 0, "R4", "byte enables within chunk mask", DW'(be_bad), 0);
    begin
      int mism = 0;
      for (int l = 0; l < 64; l++) if (shd_mem[l] != ref_mem[l]) mism++;
      chk(mism == 0, "R5", "all lines in program order", DW'(mism), 0);
    end
    summary();
    $finish;
  end
endmodule